// File: doc/BRIEF.md
# Hot-Plug Detect Router with Interrupt-Tolerant Filter

This block sits between a graphics source, a built-in display panel and an external connector. It routes hot-plug-detect levels among them. A mode input selects one of two arrangements:

- **Normal mode:** the source drives the external display through the connector. The connector's HPD pin is an input.
- **External-source mode:** an outside source shows video on the built-in panel. The block drives the connector's HPD pin with the panel's level.

The block also produces a filtered connector-HPD flag. A sink signals an interrupt by pulling HPD low for about a millisecond. The flag ignores such pulses, and only a low held for several milliseconds counts as an unplug. The flag rises without delay beyond synchronization. Time is measured in ticks of an enable input, normally 1 kHz. The number of ticks that a low must persist is set by a parameter.

Both HPD inputs are asynchronous and pass through two-flop synchronizers. The mode input is registered once. The registered mode drives the pin output enable directly.

Top module: `hpd_router`

## Requirements
- R1: A low on the filter input that lasts through fewer than FALL_TICKS consecutive ticks never drives the filtered flag low.
- R2: When the filter input stays low through FALL_TICKS consecutive ticks, the flag drops at the clock edge that samples the FALL_TICKS-th tick.
- R3: A high on the filter input sets the flag on the next clock edge. This is three edges after the pin rises. It also clears the low-time count, so a later low needs the full FALL_TICKS ticks again.
- R4: In normal mode (registered path select = 0), the connector HPD output enable is 0.
- R5: In normal mode, the internal-display HPD output to the source equals the panel HPD input delayed by two clock edges. The filter input is the synchronized connector HPD input.
- R6: In normal mode, the source-side external HPD output equals the filtered flag.
- R7: In external-source mode (registered path select = 1), the output enable is 1 and the connector HPD drive value equals the synchronized panel HPD.
- R8: In external-source mode, the source-side external HPD output is 0 and the internal HPD output still follows the panel.
- R9: In external-source mode, the filter input is the driven panel level, and the connector HPD input has no effect on the flag.
- R10: During reset, all outputs are 0 and the output enable is off.
- R11: A change of path select takes effect on the output enable one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase enable pulse |
| path_sel_i | input | 1 | 0 = normal mode, 1 = external-source mode |
| panel_hpd_i | input | 1 | HPD level from the built-in panel (asynchronous) |
| ext_hpd_i | input | 1 | Level seen on the connector HPD pin (asynchronous) |
| ext_hpd_o | output | 1 | Value driven onto the connector HPD pin |
| ext_hpd_oe | output | 1 | Output enable for the connector HPD pin |
| src_int_hpd_o | output | 1 | Built-in display HPD, toward the source |
| src_ext_hpd_o | output | 1 | External display HPD, toward the source |
| ext_hpd_flt_o | output | 1 | Filtered connector HPD flag |

## Verification
The bench builds the block with FALL_TICKS = 4 and issues a tick every ten clocks. A sink interrupt pulse therefore spans two or three ticks, and a real unplug takes a few tens of cycles, so both outcomes appear in a short run. With this setting, lows that straddle the tick boundary near the threshold arise naturally. Mode switches in both directions are also reachable, while the connector input toggles and the panel falls long enough to drop the flag.

// File: rtl/hpd_router_pkg.sv
package hpd_router_pkg;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_EXT_SRC = 1'b1
  } hpd_mode_e;

  // True when the tick now being counted completes the low-time window.
  function automatic logic fall_due(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/hpd_fall_filter.sv
module hpd_fall_filter
  import hpd_router_pkg::*;
#(
  parameter int FALL_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic lvl_i,
  output logic flt_o,
  output logic fall_evt_o
);
  localparam int CNT_W = $clog2(FALL_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flt_q;
  logic             count_en;

  assign count_en   = !lvl_i && flt_q && tick_i;
  assign fall_evt_o = count_en && fall_due(32'(cnt_q), FALL_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (lvl_i) begin
      flt_q <= 1'b1;
      cnt_q <= '0;
    end else if (fall_evt_o) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (count_en) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (!flt_q) begin
      cnt_q <= '0;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/hpd_route.sv
module hpd_route
  import hpd_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic path_sel_i,
  input  logic panel_s_i,
  input  logic ext_s_i,
  input  logic flt_i,
  output logic filt_lvl_o,
  output logic ext_hpd_o,
  output logic ext_hpd_oe,
  output logic src_int_hpd_o,
  output logic src_ext_hpd_o
);
  hpd_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= hpd_mode_e'(path_sel_i);
  end

  always_comb begin
    ext_hpd_oe    = 1'b0;
    ext_hpd_o     = 1'b0;
    filt_lvl_o    = ext_s_i;
    src_ext_hpd_o = flt_i;
    src_int_hpd_o = panel_s_i;
    if (mode_q == MODE_EXT_SRC) begin
      ext_hpd_oe    = 1'b1;
      ext_hpd_o     = panel_s_i;
      filt_lvl_o    = panel_s_i;
      src_ext_hpd_o = 1'b0;
    end
  end
endmodule

// File: rtl/hpd_router.sv
module hpd_router
  import hpd_router_pkg::*;
#(
  parameter int FALL_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic path_sel_i,
  input  logic panel_hpd_i,
  input  logic ext_hpd_i,
  output logic ext_hpd_o,
  output logic ext_hpd_oe,
  output logic src_int_hpd_o,
  output logic src_ext_hpd_o,
  output logic ext_hpd_flt_o
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in, syn_in;
  logic            filt_lvl;
  logic            flt;
  logic            fall_evt;

  assign raw_in = {panel_hpd_i, ext_hpd_i};

  hpd_sync #(.W(N_IN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  hpd_route u_route (
    .clk           (clk),
    .rst_n         (rst_n),
    .path_sel_i    (path_sel_i),
    .panel_s_i     (syn_in[1]),
    .ext_s_i       (syn_in[0]),
    .flt_i         (flt),
    .filt_lvl_o    (filt_lvl),
    .ext_hpd_o     (ext_hpd_o),
    .ext_hpd_oe    (ext_hpd_oe),
    .src_int_hpd_o (src_int_hpd_o),
    .src_ext_hpd_o (src_ext_hpd_o)
  );

  hpd_fall_filter #(.FALL_TICKS(FALL_TICKS)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .lvl_i      (filt_lvl),
    .flt_o      (flt),
    .fall_evt_o (fall_evt)
  );

  assign ext_hpd_flt_o = flt;
endmodule

// File: rtl/hpd_router_chk.sv
module hpd_router_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic path_sel_i,
  input logic filt_in,
  input logic fall_evt,
  input logic ext_hpd_o,
  input logic ext_hpd_oe,
  input logic src_int_hpd_o,
  input logic src_ext_hpd_o,
  input logic ext_hpd_flt_o
);
  // R1, R2: the flag only drops on a tick while the filter input is low
  p_fall_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_hpd_flt_o) |-> ($past(tick_i) && !$past(filt_in)));

  // R1: the flag never drops without the counted window completing
  p_no_early_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_hpd_flt_o) && !$past(fall_evt)) |-> ext_hpd_flt_o);

  // R3: a high filter input sets the flag on the next edge
  p_fast_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    filt_in |=> ext_hpd_flt_o);

  // R4, R11: the enable follows path select one edge later
  p_oe_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ext_hpd_oe == $past(path_sel_i)));

  // R6: normal mode reports the flag as the external HPD
  p_src_ext_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_hpd_oe |-> (src_ext_hpd_o == ext_hpd_flt_o));

  // R7: the driven value is the panel level
  p_drive_panel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hpd_oe |-> (ext_hpd_o == src_int_hpd_o));

  // R8: external-source mode forces the source-side external HPD low
  p_src_ext_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hpd_oe |-> !src_ext_hpd_o);
endmodule

bind hpd_router hpd_router_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .path_sel_i    (path_sel_i),
  .filt_in       (filt_lvl),
  .fall_evt      (fall_evt),
  .ext_hpd_o     (ext_hpd_o),
  .ext_hpd_oe    (ext_hpd_oe),
  .src_int_hpd_o (src_int_hpd_o),
  .src_ext_hpd_o (src_ext_hpd_o),
  .ext_hpd_flt_o (ext_hpd_flt_o)
);

// File: tb/sim_hpd_router.sv
module sim_hpd_router;
  localparam int FT   = 4;
  localparam int TDIV = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, path = 1'b0, panel = 1'b0, ext = 1'b0;
  logic ext_o, oe, s_int, s_ext, flt;

  hpd_router #(.FALL_TICKS(FT)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick),
    .path_sel_i    (path),
    .panel_hpd_i   (panel),
    .ext_hpd_i     (ext),
    .ext_hpd_o     (ext_o),
    .ext_hpd_oe    (oe),
    .src_int_hpd_o (s_int),
    .src_ext_hpd_o (s_ext),
    .ext_hpd_flt_o (flt)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0, seen_low = 1'b0;

  // Behavioural reference: pipelined samples and a tick counter
  bit q_pan[$] = '{0, 0};
  bit q_ext[$] = '{0, 0};
  bit m_path = 0, m_flt = 0;
  int m_cnt = 0;

  always @(posedge clk) begin
    bit pan_now, ext_now, lvl;
    if (!rst_n) begin
      q_pan = '{0, 0}; q_ext = '{0, 0};
      m_path = 0; m_flt = 0; m_cnt = 0;
    end else begin
      pan_now = q_pan[0];
      ext_now = q_ext[0];
      lvl = m_path ? pan_now : ext_now;
      if (lvl) begin
        m_flt = 1; m_cnt = 0;
      end else if (m_flt && tick) begin
        m_cnt++;
        if (m_cnt >= FT) begin m_flt = 0; m_cnt = 0; end
      end else if (!m_flt) m_cnt = 0;
      m_path = path;
      void'(q_pan.pop_front()); q_pan.push_back(panel);
      void'(q_ext.pop_front()); q_ext.push_back(ext);
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      chk("R4 R7 R11 oe", oe, m_path);
      chk("R7 drive", ext_o, m_path & q_pan[0]);
      chk("R5 R8 src_int", s_int, q_pan[0]);
      chk("R6 R8 src_ext", s_ext, !m_path & m_flt);
      chk("R1 R2 R3 R9 flag", flt, m_flt);
      if (!flt) seen_low = 1'b1;
      cyc++;
      tick = (cyc % TDIV == 0);
    end
  endtask

  initial begin
    step(4);
    chk("R10 reset oe", oe, 1'b0);
    chk("R10 reset flag", flt, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    panel = 1; ext = 1;
    step(30);
    chk("R3 flag up", flt, 1'b1);
    chk("R5 panel seen", s_int, 1'b1);
    // sink interrupt pulse, about two ticks
    seen_low = 0; ext = 0; step(22); ext = 1; step(20);
    chk("R1 short low swallowed", seen_low, 1'b0);
    // pulse near the threshold: three ticks
    seen_low = 0; ext = 0; step(31); ext = 1; step(20);
    chk("R1 three tick low swallowed", seen_low, 1'b0);
    // real unplug
    ext = 0; step(80);
    chk("R2 long low falls", flt, 1'b0);
    chk("R6 src_ext low", s_ext, 1'b0);
    ext = 1; step(4);
    chk("R3 rise quick", flt, 1'b1);
    panel = 0; step(5); panel = 1; step(5);
    // external-source mode
    path = 1; ext = 0; step(3);
    chk("R11 oe on", oe, 1'b1);
    step(20);
    chk("R7 drive panel", ext_o, 1'b1);
    chk("R8 src_ext forced", s_ext, 1'b0);
    chk("R9 ext ignored", flt, 1'b1);
    repeat (5) begin ext = ~ext; step(7); end
    panel = 0; step(80);
    chk("R9 panel low filtered", flt, 1'b0);
    chk("R8 src_int follows", s_int, 1'b0);
    panel = 1; step(10);
    path = 0; ext = 1; step(3);
    chk("R4 oe off", oe, 1'b0);
    step(30);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule